// File: doc/BRIEF.md
# UART Channel Command Decoder

This block sits behind the write-only command register of one serial channel. Each byte written to that register carries two independent fields. The upper nibble is a coded housekeeping command: reset the receiver, reset the transmitter, clear the error flags, clear the break-change interrupt, or send the mode-register pointer back to its first register. The lower nibble holds separate enable and disable bits for the transmitter and the receiver. The block turns these fields into held enable state, one-cycle action pulses and the mode-register pointer for the rest of the channel.

Coded commands must be spaced apart by a minimum number of edges of the baud reference clock. That clock reaches this block as a one-cycle strobe, `ref_edge`. A coded command that arrives too early is dropped and flagged. The enable and disable bits in the same write still take effect.

Disabling the transmitter clears its ready and empty flags at once, but the transmitter keeps running until the character being shifted and the FIFO contents are gone. Disabling the receiver takes effect immediately and discards any character in flight.

Top module: `uart_cmd_ctrl`

## Requirements
- R1: While reset is asserted and after its release, tx_en, tx_rdy, tx_emt, rx_en and mr_ptr are 0, all pulse outputs are 0, and the first coded command is accepted without waiting for reference edges.
- R2: A write whose bits 7:4 are 0010 pulses rst_rx_p, 0011 pulses rst_tx_p, 0100 pulses clr_err_p and 0101 pulses clr_brk_p. Each pulse lasts one cycle and is high in the cycle after the write. Codes 0000 and 0110 to 1111 cause no action and no rejection.
- R3: A coded command (codes 0001 to 0101) is accepted only if at least GAP (default 3) ref_edge strobes have occurred since the previously accepted coded command. A ref_edge in the same cycle as an accepted command is not counted. Otherwise the command is ignored and cmd_reject pulses for one cycle, in the cycle after the write.
- R4: The enable and disable bits 3:0 of a write take effect whether or not the coded command in the same write is rejected.
- R5: Code 0001 sets mr_ptr to 0 in the cycle after the write. Each mr_access strobe advances mr_ptr by one, saturating at NUM_MR-1 (default 2). If both happen in one cycle, code 0001 wins.
- R6: Bit 2 (enable transmitter) sets tx_en and tx_rdy in the cycle after the write. While the transmitter is enabled, tx_emt equals the idle condition (tx_busy low and tx_fifo_empty high) as sampled on the previous clock.
- R7: Bit 3 (disable transmitter) clears tx_rdy and tx_emt in the cycle after the write. tx_en stays 1 until a clock edge samples the transmitter idle, and falls in the following cycle. A later bit-2 write during this drain re-enables the transmitter.
- R8: Bit 0 (enable receiver) sets rx_en and pulses rx_hunt for one cycle. Bit 1 (disable receiver) clears rx_en in the next cycle and pulses rx_drop if rx_en and rx_busy were both high. Neither bit changes any transmitter output or mr_ptr.
- R9: A write with both bits 3 and 2 set, or both bits 1 and 0 set, acts as the disable for that direction and pulses conflict for one cycle.
- R10: An accepted receiver reset clears rx_en and suppresses rx_hunt, overriding bit 0 of the same write. An accepted transmitter reset clears tx_en, tx_rdy and tx_emt at once with no drain, overriding bit 2 of the same write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Command register write strobe |
| wr_data | input | 8 | Command byte |
| ref_edge | input | 1 | One-cycle strobe per reference clock edge |
| mr_access | input | 1 | Strobe: a mode register was accessed |
| tx_busy | input | 1 | Transmit shifter is sending a character |
| tx_fifo_empty | input | 1 | Transmit FIFO holds no data |
| rx_busy | input | 1 | Receiver is assembling a character |
| tx_en | output | 1 | Transmitter operating (includes drain) |
| tx_rdy | output | 1 | Transmitter ready flag enable |
| tx_emt | output | 1 | Transmitter empty flag |
| rx_en | output | 1 | Receiver enabled |
| rx_hunt | output | 1 | Pulse: start searching for a start bit |
| rx_drop | output | 1 | Pulse: discard character in progress |
| rst_rx_p | output | 1 | Pulse: reset receiver and flush its FIFO |
| rst_tx_p | output | 1 | Pulse: reset transmitter |
| clr_err_p | output | 1 | Pulse: clear break, parity, framing and overrun flags |
| clr_brk_p | output | 1 | Pulse: clear break-change interrupt |
| cmd_reject | output | 1 | Pulse: coded command refused for spacing |
| conflict | output | 1 | Pulse: enable and disable set for one direction |
| mr_ptr | output | $clog2(NUM_MR) | Mode register pointer |

## Verification
Every output of this block is registered once behind the write, so each pulse, enable change, flag clear and pointer update is due exactly one clock after the edge that samples the write or strobe. The one exception is the drain end, which falls one clock after the edge that first sees the transmitter idle. The bench drives inputs on the falling edge and pushes the expected outputs for the coming rising edge into a queue. The monitor pops and compares 2 ns after that rising edge, so every comparison lands in the cycle the result is due. Spacing cases count ref_edge strobes explicitly: GAP-1 strobes must be refused and GAP strobes accepted.

// File: rtl/uart_cmd_pkg.sv
package uart_cmd_pkg;

  localparam int CMD_W = 8;

  // Coded commands carried in bits 7:4 of the command byte
  localparam logic [3:0] MC_NOP     = 4'h0;
  localparam logic [3:0] MC_MR_HOME = 4'h1;
  localparam logic [3:0] MC_RST_RX  = 4'h2;
  localparam logic [3:0] MC_RST_TX  = 4'h3;
  localparam logic [3:0] MC_CLR_ERR = 4'h4;
  localparam logic [3:0] MC_CLR_BRK = 4'h5;

  // Bit positions of the direct enable/disable bits
  localparam int B_TX_DIS = 3;
  localparam int B_TX_EN  = 2;
  localparam int B_RX_DIS = 1;
  localparam int B_RX_EN  = 0;

  typedef enum logic [1:0] {
    TXS_OFF   = 2'd0,
    TXS_ON    = 2'd1,
    TXS_DRAIN = 2'd2
  } tx_state_e;

  typedef struct packed {
    logic home;
    logic rst_rx;
    logic rst_tx;
    logic clr_err;
    logic clr_brk;
  } misc_act_t;

endpackage

// File: rtl/cmd_misc_gate.sv
module cmd_misc_gate
  import uart_cmd_pkg::*;
#(
  parameter int GAP = 3
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  logic [3:0] code,
  input  logic      ref_edge,
  output misc_act_t act,
  output misc_act_t act_q,
  output logic      reject_q
);

  localparam int CNT_W = $clog2(GAP + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(GAP);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             is_misc, gap_ok, take, reject_d;

  always_comb begin
    is_misc  = (code >= MC_MR_HOME) && (code <= MC_CLR_BRK);
    gap_ok   = (cnt_q >= CNT_FULL);
    take     = wr_en && is_misc && gap_ok;
    reject_d = wr_en && is_misc && !gap_ok;
    act      = '0;
    if (take) begin
      unique case (code)
        MC_MR_HOME: act.home    = 1'b1;
        MC_RST_RX:  act.rst_rx  = 1'b1;
        MC_RST_TX:  act.rst_tx  = 1'b1;
        MC_CLR_ERR: act.clr_err = 1'b1;
        MC_CLR_BRK: act.clr_brk = 1'b1;
        default:    act         = '0;
      endcase
    end
    if (take) begin
      cnt_d = '0;
    end else if (ref_edge && !gap_ok) begin
      cnt_d = cnt_q + 1'b1;
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= CNT_FULL;
      act_q    <= '0;
      reject_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      act_q    <= act;
      reject_q <= reject_d;
    end
  end

endmodule

// File: rtl/cmd_tx_ctl.sv
module cmd_tx_ctl
  import uart_cmd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic dis_cmd,
  input  logic en_cmd,
  input  logic rst_cmd,
  input  logic busy,
  input  logic fifo_empty,
  output logic tx_en,
  output logic tx_rdy,
  output logic tx_emt
);

  tx_state_e st_q, st_d;
  logic      emt_q, emt_d, idle;

  always_comb begin
    idle = !busy && fifo_empty;
    st_d = st_q;
    if (rst_cmd) begin
      st_d = TXS_OFF;
    end else if (dis_cmd) begin
      if (st_q == TXS_OFF || idle) st_d = TXS_OFF;
      else                         st_d = TXS_DRAIN;
    end else if (en_cmd) begin
      st_d = TXS_ON;
    end else if (st_q == TXS_DRAIN && idle) begin
      st_d = TXS_OFF;
    end
    emt_d = (st_d == TXS_ON) && idle;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= TXS_OFF;
      emt_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      emt_q <= emt_d;
    end
  end

  assign tx_en  = (st_q != TXS_OFF);
  assign tx_rdy = (st_q == TXS_ON);
  assign tx_emt = emt_q;

endmodule

// File: rtl/cmd_rx_ctl.sv
module cmd_rx_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic dis_cmd,
  input  logic en_cmd,
  input  logic rst_cmd,
  input  logic rx_busy,
  output logic rx_en,
  output logic rx_hunt,
  output logic rx_drop
);

  logic en_q, en_d, hunt_d, drop_d;
  logic hunt_q, drop_q;

  always_comb begin
    en_d   = en_q;
    hunt_d = 1'b0;
    drop_d = dis_cmd && en_q && rx_busy;
    if (rst_cmd || dis_cmd) begin
      en_d = 1'b0;
    end else if (en_cmd) begin
      en_d   = 1'b1;
      hunt_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      hunt_q <= 1'b0;
      drop_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      hunt_q <= hunt_d;
      drop_q <= drop_d;
    end
  end

  assign rx_en   = en_q;
  assign rx_hunt = hunt_q;
  assign rx_drop = drop_q;

endmodule

// File: rtl/uart_cmd_ctrl.sv
module uart_cmd_ctrl
  import uart_cmd_pkg::*;
#(
  parameter int GAP    = 3,
  parameter int NUM_MR = 3,
  localparam int PTR_W = (NUM_MR > 1) ? $clog2(NUM_MR) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CMD_W-1:0] wr_data,
  input  logic             ref_edge,
  input  logic             mr_access,
  input  logic             tx_busy,
  input  logic             tx_fifo_empty,
  input  logic             rx_busy,
  output logic             tx_en,
  output logic             tx_rdy,
  output logic             tx_emt,
  output logic             rx_en,
  output logic             rx_hunt,
  output logic             rx_drop,
  output logic             rst_rx_p,
  output logic             rst_tx_p,
  output logic             clr_err_p,
  output logic             clr_brk_p,
  output logic             cmd_reject,
  output logic             conflict,
  output logic [PTR_W-1:0] mr_ptr
);

  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(NUM_MR - 1);

  misc_act_t  act, act_q;
  logic       tx_dis, tx_en_cmd, rx_dis, rx_en_cmd;
  logic       conf_d, conf_q;
  logic [PTR_W-1:0] ptr_q, ptr_d;

  // Direct bits: a disable in the same write masks the matching enable
  always_comb begin
    tx_dis    = wr_en && wr_data[B_TX_DIS];
    rx_dis    = wr_en && wr_data[B_RX_DIS];
    tx_en_cmd = wr_en && wr_data[B_TX_EN] && !wr_data[B_TX_DIS];
    rx_en_cmd = wr_en && wr_data[B_RX_EN] && !wr_data[B_RX_DIS];
    conf_d    = wr_en && ((wr_data[B_TX_DIS] && wr_data[B_TX_EN]) ||
                          (wr_data[B_RX_DIS] && wr_data[B_RX_EN]));
  end

  cmd_misc_gate #(.GAP(GAP)) u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .code     (wr_data[CMD_W-1:CMD_W-4]),
    .ref_edge (ref_edge),
    .act      (act),
    .act_q    (act_q),
    .reject_q (cmd_reject)
  );

  cmd_tx_ctl u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .dis_cmd    (tx_dis),
    .en_cmd     (tx_en_cmd),
    .rst_cmd    (act.rst_tx),
    .busy       (tx_busy),
    .fifo_empty (tx_fifo_empty),
    .tx_en      (tx_en),
    .tx_rdy     (tx_rdy),
    .tx_emt     (tx_emt)
  );

  cmd_rx_ctl u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .dis_cmd (rx_dis),
    .en_cmd  (rx_en_cmd),
    .rst_cmd (act.rst_rx),
    .rx_busy (rx_busy),
    .rx_en   (rx_en),
    .rx_hunt (rx_hunt),
    .rx_drop (rx_drop)
  );

  // Mode register pointer: home command beats an access advance
  always_comb begin
    ptr_d = ptr_q;
    if (act.home) begin
      ptr_d = '0;
    end else if (mr_access && (ptr_q != PTR_LAST)) begin
      ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      conf_q <= 1'b0;
    end else begin
      ptr_q  <= ptr_d;
      conf_q <= conf_d;
    end
  end

  assign mr_ptr    = ptr_q;
  assign conflict  = conf_q;
  assign rst_rx_p  = act_q.rst_rx;
  assign rst_tx_p  = act_q.rst_tx;
  assign clr_err_p = act_q.clr_err;
  assign clr_brk_p = act_q.clr_brk;

endmodule

// File: rtl/uart_cmd_ctrl_chk.sv
module uart_cmd_ctrl_chk #(
  parameter int NUM_MR = 3,
  localparam int PTR_W = (NUM_MR > 1) ? $clog2(NUM_MR) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [7:0]       wr_data,
  input logic             tx_en,
  input logic             tx_rdy,
  input logic             tx_emt,
  input logic             rx_en,
  input logic             rx_hunt,
  input logic             rst_rx_p,
  input logic             rst_tx_p,
  input logic             clr_err_p,
  input logic             clr_brk_p,
  input logic             cmd_reject,
  input logic             conflict,
  input logic [PTR_W-1:0] mr_ptr
);

  logic any_pulse, misc_wr;
  assign any_pulse = rst_rx_p || rst_tx_p || clr_err_p || clr_brk_p;
  assign misc_wr   = wr_en && (wr_data[7:4] >= 4'h1) && (wr_data[7:4] <= 4'h5);

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rst_rx_p, rst_tx_p, clr_err_p, clr_brk_p, cmd_reject})); // R2

  AST_REJECT_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reject |-> $past(wr_en)); // R3

  AST_TOO_SOON: assert property (@(posedge clk) disable iff (!rst_n)
    (any_pulse && misc_wr) |=> cmd_reject); // R3

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    mr_ptr <= PTR_W'(NUM_MR - 1)); // R5

  AST_RDY_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rdy |-> tx_en); // R6

  AST_TX_DIS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[3]) |=> (!tx_rdy && !tx_emt)); // R7

  AST_RX_DIS_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[1]) |=> !rx_en); // R8

  AST_HUNT_WITH_EN: assert property (@(posedge clk) disable iff (!rst_n)
    rx_hunt |-> rx_en); // R8

  AST_CONFLICT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ((wr_data[3] && wr_data[2]) || (wr_data[1] && wr_data[0]))) |=> conflict); // R9

endmodule

bind uart_cmd_ctrl uart_cmd_ctrl_chk #(.NUM_MR(NUM_MR)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .tx_en      (tx_en),
  .tx_rdy     (tx_rdy),
  .tx_emt     (tx_emt),
  .rx_en      (rx_en),
  .rx_hunt    (rx_hunt),
  .rst_rx_p   (rst_rx_p),
  .rst_tx_p   (rst_tx_p),
  .clr_err_p  (clr_err_p),
  .clr_brk_p  (clr_brk_p),
  .cmd_reject (cmd_reject),
  .conflict   (conflict),
  .mr_ptr     (mr_ptr)
);

// File: tb/uart_cmd_ctrl_test.sv
module uart_cmd_ctrl_test;

  localparam int GAP    = 3;
  localparam int NUM_MR = 3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, ref_edge, mr_access, tx_busy, tx_fifo_empty, rx_busy;
  logic [7:0] wr_data;
  logic       tx_en, tx_rdy, tx_emt, rx_en, rx_hunt, rx_drop;
  logic       rst_rx_p, rst_tx_p, clr_err_p, clr_brk_p, cmd_reject, conflict;
  logic [1:0] mr_ptr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  uart_cmd_ctrl #(.GAP(GAP), .NUM_MR(NUM_MR)) uut (.*);

  typedef struct packed {
    logic tx_en, tx_rdy, tx_emt, rx_en, rx_hunt, rx_drop;
    logic rst_rx, rst_tx, clr_err, clr_brk, reject, conflict;
    logic [1:0] ptr;
  } exp_t;

  exp_t sb_q[$];

  // Reference state derived from the requirements
  int m_cnt, m_tx, m_ptr;  // m_tx: 0 off, 1 on, 2 drain
  bit m_emt, m_rx;

  task automatic chk(string tag, string nm, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, nm, act, exp, $time);
    end
  endtask

  task automatic cyc(bit w, logic [7:0] d, bit re = 0, bit ma = 0,
                     bit tb = 0, bit te = 1, bit rb = 0);
    exp_t e;
    bit misc, acc, idle, tdis, ten, rdis, ren;
    int code;
    @(negedge clk);
    wr_en = w; wr_data = d; ref_edge = re; mr_access = ma;
    tx_busy = tb; tx_fifo_empty = te; rx_busy = rb;
    code = d[7:4];
    misc = w && code >= 1 && code <= 5;
    acc  = misc && m_cnt >= GAP;
    e = '0;
    e.reject  = misc && !acc;
    e.rst_rx  = acc && code == 2;
    e.rst_tx  = acc && code == 3;
    e.clr_err = acc && code == 4;
    e.clr_brk = acc && code == 5;
    e.conflict = w && ((d[3] && d[2]) || (d[1] && d[0]));
    if (acc) m_cnt = 0; else if (re && m_cnt < GAP) m_cnt++;
    if (acc && code == 1) m_ptr = 0; else if (ma && m_ptr < NUM_MR - 1) m_ptr++;
    idle = !tb && te;
    tdis = w && d[3]; ten = w && d[2] && !d[3];
    rdis = w && d[1]; ren = w && d[0] && !d[1];
    if (e.rst_tx) m_tx = 0;
    else if (tdis) m_tx = (m_tx == 0 || idle) ? 0 : 2;
    else if (ten) m_tx = 1;
    else if (m_tx == 2 && idle) m_tx = 0;
    m_emt = (m_tx == 1) && idle;
    e.rx_drop = rdis && m_rx && rb;
    e.rx_hunt = 0;
    if (e.rst_rx || rdis) m_rx = 0;
    else if (ren) begin m_rx = 1; e.rx_hunt = 1; end
    e.tx_en = m_tx != 0; e.tx_rdy = m_tx == 1; e.tx_emt = m_emt;
    e.rx_en = m_rx; e.ptr = 2'(m_ptr);
    sb_q.push_back(e);
  endtask

  task automatic idle_n(int n, bit re = 0);
    for (int i = 0; i < n; i++) cyc(0, 8'h00, re);
  endtask

  // Monitor: compare 2 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        chk("R6/R7/R10", "tx_en",  tx_en,  e.tx_en);
        chk("R6/R7",     "tx_rdy", tx_rdy, e.tx_rdy);
        chk("R6/R7",     "tx_emt", tx_emt, e.tx_emt);
        chk("R8/R10",    "rx_en",  rx_en,  e.rx_en);
        chk("R8",        "rx_hunt", rx_hunt, e.rx_hunt);
        chk("R8",        "rx_drop", rx_drop, e.rx_drop);
        chk("R2",        "rst_rx_p", rst_rx_p, e.rst_rx);
        chk("R2",        "rst_tx_p", rst_tx_p, e.rst_tx);
        chk("R2",        "clr_err_p", clr_err_p, e.clr_err);
        chk("R2",        "clr_brk_p", clr_brk_p, e.clr_brk);
        chk("R3",        "cmd_reject", cmd_reject, e.reject);
        chk("R9",        "conflict", conflict, e.conflict);
        chk("R5",        "mr_ptr", mr_ptr, e.ptr);
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; wr_en = 0; wr_data = 0; ref_edge = 0; mr_access = 0;
    tx_busy = 0; tx_fifo_empty = 1; rx_busy = 0;
    m_cnt = GAP; m_tx = 0; m_ptr = 0; m_emt = 0; m_rx = 0;
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    chk("R1", "reset outputs",
        int'({tx_en, tx_rdy, tx_emt, rx_en, rx_hunt, rx_drop, rst_rx_p,
              rst_tx_p, clr_err_p, clr_brk_p, cmd_reject, conflict}), 0);
    chk("R1", "reset mr_ptr", mr_ptr, 0);
    @(negedge clk); rst_n = 1;
    idle_n(2);
    // R1/R2: first coded command accepted at once; R6/R8 enable both
    cyc(1, 8'h45);
    // R3: too soon -> reject; R4: low nibble still disables receiver
    cyc(1, 8'h52);
    // R3: GAP-1 edges, still rejected
    idle_n(GAP - 1, 1);
    cyc(1, 8'h50);
    // one more edge, accepted
    idle_n(1, 1);
    cyc(1, 8'h50);
    // R2: reserved codes do nothing
    cyc(1, 8'h70); cyc(1, 8'hF0); cyc(1, 8'h00);
    // R3: edge in same cycle as accepted command not counted
    idle_n(GAP, 1);
    cyc(1, 8'h40, 1);
    idle_n(GAP - 1, 1);
    cyc(1, 8'h40);
    idle_n(GAP, 1);
    // R5: pointer advance saturates, home resets
    for (int i = 0; i < 4; i++) cyc(0, 8'h00, 0, 1);
    cyc(1, 8'h10, 0, 1);
    cyc(0, 8'h00, 0, 1);
    idle_n(GAP, 1);
    // R6: tx_emt follows idle while enabled
    cyc(0, 8'h00, 0, 0, 1, 0);
    cyc(0, 8'h00, 0, 0, 0, 1);
    // R7: disable while busy drains
    cyc(1, 8'h08, 0, 0, 1, 0);
    cyc(0, 8'h00, 0, 0, 1, 0);
    cyc(0, 8'h00, 0, 0, 0, 0);
    cyc(0, 8'h00, 0, 0, 0, 1);
    idle_n(2);
    // R7: re-enable during drain
    cyc(1, 8'h04);
    cyc(1, 8'h08, 0, 0, 1, 1);
    cyc(1, 8'h04, 0, 0, 1, 1);
    // R9: conflicts
    cyc(1, 8'h0C, 0, 0, 1, 1);
    cyc(0, 8'h00, 0, 0, 0, 1);
    cyc(1, 8'h03);
    // R8: receiver disable while busy drops character
    cyc(1, 8'h01);
    cyc(1, 8'h02, 0, 0, 0, 1, 1);
    cyc(1, 8'h02, 0, 0, 0, 1, 1);
    // R10: resets override enables
    cyc(1, 8'h05);
    cyc(1, 8'h34);
    idle_n(GAP, 1);
    cyc(1, 8'h21);
    idle_n(GAP, 1);
    cyc(1, 8'h01, 0, 0, 1, 0);
    cyc(1, 8'h30, 0, 0, 1, 0);
    idle_n(3);
    repeat (2) @(posedge clk);
    #3;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule